// File: doc/BRIEF.md
# Eight-Source Prioritized Interrupt Controller

This block gathers eight interrupt request lines for a small 16-bit handheld processor. Each request latches into a status byte. An enable byte masks the status. The highest-numbered pending and enabled source is turned into a vector number, which is the sum of a programmable base and the source's bit position. The processor reaches the block through a byte-wide port bus at offsets 0xB0 to 0xB7. The base sits at 0xB0, the enable at 0xB2, the status at 0xB4 for reads, and the acknowledge at 0xB6 for writes.

A wake output releases a halted processor whenever anything is both pending and enabled, even if the processor's interrupt flag is clear. A vector is offered only at an instruction boundary, with the flag set and polling not inhibited. Polling is inhibited after prefix bytes, stack-segment loads, flag pops, interrupt returns and flag-set instructions. Once a vector is offered, the block holds it until the processor acknowledges it. Status bits are cleared only by software, through the acknowledge port, or by the source itself. The model parameter selects between the monochrome and colour rules for the base register.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the base, enable and status ports read 0x00, and irq_req and wake are 0.
- R2: A pulse on src_set[i] sets status bit i whatever the enable byte holds, and the bit stays set afterwards.
- R3: Writing a byte to offset 0xB6 clears every status bit that is 1 in that byte. src_clr[i] clears bit i. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R4: On the colour model (MONO=0), a base write stores the byte with bit 0 cleared. On the monochrome model (MONO=1), a write keeps only bits 7:3, and a read returns the stored value with bits 1:0 forced to 1.
- R5: wake is 1 in every cycle in which status AND enable is nonzero, independent of cpu_if.
- R6: Suppose status AND enable is nonzero while irq_req is 0, insn_boundary is 1, cpu_if is 1 and poll_inhibit is 0. Then from the next cycle irq_req is 1, and irq_vec equals base plus the index of the highest set bit of status AND enable, modulo 256. Bit 7 is the horizontal-blank timer source and bit 6 is the vertical-blank source.
- R7: No vector is offered when cpu_if is 0, poll_inhibit is 1, insn_boundary is 0, or nothing is pending and enabled.
- R8: While irq_req is 1 and irq_ack is 0, irq_req and irq_vec stay unchanged, even if new sources arrive. The cycle after irq_ack, irq_req is 0. Delivery does not clear any status bit.
- R9: Reads of 0xB1, 0xB3, 0xB5, 0xB6, 0xB7, or any address outside 0xB0 to 0xB7, return 0x00. A write to 0xB4 leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_set | input | NSRC | Per-source request pulse, sets the status bit |
| src_clr | input | NSRC | Per-source withdraw, clears the status bit |
| io_addr | input | 8 | Port address |
| io_wr | input | 1 | Port write strobe |
| io_wdata | input | 8 | Port write data |
| io_rdata | output | 8 | Port read data, combinational from io_addr |
| cpu_if | input | 1 | Processor interrupt-enable flag |
| insn_boundary | input | 1 | Processor is between instructions |
| poll_inhibit | input | 1 | Skip polling at this boundary |
| irq_ack | input | 1 | Processor has accepted the offered vector |
| wake | output | 1 | Halt release: something pending and enabled |
| irq_req | output | 1 | A vector is being offered |
| irq_vec | output | 8 | Offered vector number |

## Verification
Two functions can act in the same cycle. A source can raise a bit in the same clock that software writes the acknowledge port with that bit set. A delivery can also be in flight when a higher-priority source arrives. The bench provokes the first case by driving src_set and an acknowledge write together, then reads the status to confirm the bit survived. It provokes the second by raising bit 7 and pulsing the boundary while a lower vector is still offered, then judges that the offered vector stays unchanged until the handshake completes.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam logic [7:0] OFS_BASE = 8'hB0;
  localparam logic [7:0] OFS_ENA  = 8'hB2;
  localparam logic [7:0] OFS_STAT = 8'hB4;
  localparam logic [7:0] OFS_ACK  = 8'hB6;

  // bit positions of the request sources inside status/enable
  typedef enum logic [2:0] {
    SRC_SER_TX   = 3'd0,
    SRC_KEYPAD   = 3'd1,
    SRC_CART     = 3'd2,
    SRC_SER_RX   = 3'd3,
    SRC_LINE_HIT = 3'd4,
    SRC_VB_TIMER = 3'd5,
    SRC_VBLANK   = 3'd6,
    SRC_HB_TIMER = 3'd7
  } src_e;

  // value kept by the base register after a write
  function automatic logic [7:0] base_store(input logic [7:0] d, input logic mono);
    return mono ? (d & 8'hF8) : (d & 8'hFE);
  endfunction

  // value returned when the base register is read
  function automatic logic [7:0] base_view(input logic [7:0] b, input logic mono);
    return mono ? (b | 8'h03) : b;
  endfunction

  // vector number offered to the processor
  function automatic logic [7:0] vec_of(input logic [7:0] base, input logic [2:0] idx);
    return base + {5'd0, idx};
  endfunction
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int NSRC = 8,
  parameter bit MONO = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_set,
  input  logic [NSRC-1:0] src_clr,
  input  logic [7:0]      io_addr,
  input  logic            io_wr,
  input  logic [7:0]      io_wdata,
  output logic [7:0]      io_rdata,
  output logic [7:0]      base_q,
  output logic [NSRC-1:0] ena_q,
  output logic [NSRC-1:0] stat_q
);
  logic            wr_base, wr_ena, wr_ack;
  logic [NSRC-1:0] ack_mask, stat_d;

  assign wr_base  = io_wr && (io_addr == OFS_BASE);
  assign wr_ena   = io_wr && (io_addr == OFS_ENA);
  assign wr_ack   = io_wr && (io_addr == OFS_ACK);
  assign ack_mask = wr_ack ? io_wdata[NSRC-1:0] : '0;
  // a new request in the same cycle beats any clear
  assign stat_d   = (stat_q & ~src_clr & ~ack_mask) | src_set;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      ena_q  <= '0;
      stat_q <= '0;
    end else begin
      if (wr_base) base_q <= base_store(io_wdata, MONO);
      if (wr_ena)  ena_q  <= io_wdata[NSRC-1:0];
      stat_q <= stat_d;
    end
  end

  always_comb begin
    case (io_addr)
      OFS_BASE: io_rdata = base_view(base_q, MONO);
      OFS_ENA:  io_rdata = 8'(ena_q);
      OFS_STAT: io_rdata = 8'(stat_q);
      default:  io_rdata = 8'h00;
    endcase
  end

  // R2: requested bits are present the following cycle
  p_set_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_set) |=> ((stat_q & $past(src_set)) == $past(src_set)));

  // R3: acknowledged bits without a simultaneous request are gone
  p_ack_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> ((stat_q & $past(io_wdata[NSRC-1:0] & ~src_set)) == '0));
endmodule

// File: rtl/irqc_resolve.sv
module irqc_resolve #(
  parameter int NSRC  = 8,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  pend,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  assign any = |pend;

  // ascending scan: the last hit is the highest-numbered bit
  always_comb begin
    idx = '0;
    for (int i = 0; i < NSRC; i++)
      if (pend[i]) idx = IDX_W'(i);
  end

  // R6: no pending bit lies above the chosen one
  p_top_pick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((pend >> idx) == NSRC'(1)));
endmodule

// File: rtl/irqc_deliver.sv
module irqc_deliver
  import irqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       any,
  input  logic [2:0] idx,
  input  logic [7:0] base,
  input  logic       cpu_if,
  input  logic       insn_boundary,
  input  logic       poll_inhibit,
  input  logic       irq_ack,
  output logic       irq_req,
  output logic [7:0] irq_vec
);
  logic poll_ok, take;

  assign poll_ok = insn_boundary && !poll_inhibit && cpu_if;
  assign take    = !irq_req && any && poll_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else if (take) begin
      irq_req <= 1'b1;
      irq_vec <= vec_of(base, idx);
    end else if (irq_req && irq_ack) begin
      irq_req <= 1'b0;
    end
  end

  // R7: an offer begins only after a permitted poll
  p_take_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(cpu_if && insn_boundary && !poll_inhibit));

  // R5: an offer implies the halt release was already raised
  p_wake_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_req) |-> $past(any));

  // R8: offer is held unchanged until acknowledged
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> (irq_req && $stable(irq_vec)));

  // R8: acknowledge withdraws the offer
  p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_ack) |=> !irq_req);
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NSRC = 8,
  parameter bit MONO = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_set,
  input  logic [NSRC-1:0] src_clr,
  input  logic [7:0]      io_addr,
  input  logic            io_wr,
  input  logic [7:0]      io_wdata,
  output logic [7:0]      io_rdata,
  input  logic            cpu_if,
  input  logic            insn_boundary,
  input  logic            poll_inhibit,
  input  logic            irq_ack,
  output logic            wake,
  output logic            irq_req,
  output logic [7:0]      irq_vec
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [7:0]       base_q;
  logic [NSRC-1:0]  ena_q, stat_q, pend;
  logic             any;
  logic [IDX_W-1:0] idx;

  irqc_regs #(.NSRC(NSRC), .MONO(MONO)) u_regs (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
    .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .base_q(base_q), .ena_q(ena_q), .stat_q(stat_q)
  );

  assign pend = stat_q & ena_q;

  irqc_resolve #(.NSRC(NSRC)) u_res (
    .clk(clk), .rst_n(rst_n), .pend(pend), .any(any), .idx(idx)
  );

  assign wake = any;

  irqc_deliver u_dlv (
    .clk(clk), .rst_n(rst_n), .any(any), .idx(3'(idx)), .base(base_q),
    .cpu_if(cpu_if), .insn_boundary(insn_boundary), .poll_inhibit(poll_inhibit),
    .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec)
  );
endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] src_set = '0, src_clr = '0, io_addr = '0, io_wdata = '0;
  logic io_wr = 1'b0, io_wr1 = 1'b0;
  logic cpu_if = 1'b0, insn_boundary = 1'b0, poll_inhibit = 1'b0, irq_ack = 1'b0;
  logic [7:0] io_rdata, irq_vec, rd1, vec1;
  logic wake, irq_req, wake1, req1;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_prio_ctrl #(.NSRC(8), .MONO(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .src_set(src_set), .src_clr(src_clr),
    .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .cpu_if(cpu_if), .insn_boundary(insn_boundary), .poll_inhibit(poll_inhibit),
    .irq_ack(irq_ack), .wake(wake), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  irq_prio_ctrl #(.NSRC(8), .MONO(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .src_set(8'h00), .src_clr(8'h00),
    .io_addr(io_addr), .io_wr(io_wr1), .io_wdata(io_wdata), .io_rdata(rd1),
    .cpu_if(1'b0), .insn_boundary(1'b0), .poll_inhibit(1'b0),
    .irq_ack(1'b0), .wake(wake1), .irq_req(req1), .irq_vec(vec1)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr1 = 1'b1;
    @(negedge clk); io_wr1 = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk); io_addr = a; #1 v = io_rdata;
  endtask

  task automatic raise(input logic [7:0] p);
    @(negedge clk); src_set = p;
    @(negedge clk); src_set = '0;
  endtask

  task automatic boundary();
    @(negedge clk); insn_boundary = 1'b1;
    @(negedge clk); insn_boundary = 1'b0; #1;
  endtask

  task automatic handshake();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0; #1;
  endtask

  function automatic int top_bit(input logic [7:0] v);
    int h = -1;
    for (int b = 0; b < 8; b++) if (v[b]) h = b;
    return h;
  endfunction

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'hB0, v); chk("R1 base", v, 8'h00);
    rd(8'hB2, v); chk("R1 enable", v, 8'h00);
    rd(8'hB4, v); chk("R1 status", v, 8'h00);
    chk("R1 irq_req", {7'd0, irq_req}, 8'h00);
    chk("R1 wake", {7'd0, wake}, 8'h00);

    // R2 latching with enable clear; R5/R7 nothing enabled
    for (int i = 0; i < 8; i++) begin
      raise(8'(1 << i));
      rd(8'hB4, v); chk("R2 sticky status", v, 8'((2 << i) - 1));
      chk("R5 wake masked", {7'd0, wake}, 8'h00);
    end
    cpu_if = 1'b1;
    boundary(); chk("R7 nothing enabled", {7'd0, irq_req}, 8'h00);

    // R3 acknowledge, source withdraw, collision
    wr(8'hB6, 8'h0F); rd(8'hB4, v); chk("R3 ack clears", v, 8'hF0);
    @(negedge clk); src_clr = 8'h80; @(negedge clk); src_clr = '0;
    rd(8'hB4, v); chk("R3 src_clr", v, 8'h70);
    @(negedge clk); src_set = 8'h01; io_addr = 8'hB6; io_wdata = 8'h11; io_wr = 1'b1;
    @(negedge clk); src_set = '0; io_wr = 1'b0;
    rd(8'hB4, v); chk("R3 set beats ack", v, 8'h61);

    // R9 unmapped / write-only / read-only ports
    wr(8'hB4, 8'h00); rd(8'hB4, v); chk("R9 status write ignored", v, 8'h61);
    rd(8'hB6, v); chk("R9 ack port reads 0", v, 8'h00);
    rd(8'hB1, v); chk("R9 B1 reads 0", v, 8'h00);
    rd(8'hB7, v); chk("R9 B7 reads 0", v, 8'h00);
    rd(8'h00, v); chk("R9 outside reads 0", v, 8'h00);

    // R4 base rules on both models
    wr(8'hB0, 8'hFF); rd(8'hB0, v); chk("R4 colour base", v, 8'hFE);
    wr1(8'hB0, 8'hFF); @(negedge clk); io_addr = 8'hB0; #1 chk("R4 mono base", rd1, 8'hFB);
    wr1(8'hB0, 8'h05); @(negedge clk); io_addr = 8'hB0; #1 chk("R4 mono low bits", rd1, 8'h03);

    // R5 wake with cpu_if clear; R7 gating
    wr(8'hB0, 8'h40);
    wr(8'hB2, 8'h01);
    cpu_if = 1'b0; #1 chk("R5 wake ignores cpu_if", {7'd0, wake}, 8'h01);
    boundary(); chk("R7 cpu_if low", {7'd0, irq_req}, 8'h00);
    cpu_if = 1'b1; poll_inhibit = 1'b1;
    boundary(); chk("R7 inhibited", {7'd0, irq_req}, 8'h00);
    poll_inhibit = 1'b0;
    repeat (3) @(negedge clk); #1 chk("R7 no boundary", {7'd0, irq_req}, 8'h00);

    // R8 hold while a higher source arrives
    boundary();
    chk("R6 offer", {7'd0, irq_req}, 8'h01);
    chk("R6 vector", irq_vec, 8'h40);
    wr(8'hB2, 8'hFF); raise(8'h80); boundary();
    chk("R8 held vector", irq_vec, 8'h40);
    chk("R8 held req", {7'd0, irq_req}, 8'h01);
    handshake(); chk("R8 drop after ack", {7'd0, irq_req}, 8'h00);
    boundary(); chk("R6 hblank timer is bit 7", irq_vec,
                    8'h40 + 8'(irqc_pkg::SRC_HB_TIMER));
    handshake();

    // R6/R8 sweep over every status pattern
    for (int p = 1; p < 256; p++) begin
      wr(8'hB6, 8'hFF);
      raise(8'(p));
      boundary();
      chk("R6 sweep req", {7'd0, irq_req}, 8'h01);
      chk("R6 sweep vec", irq_vec, 8'(8'h40 + top_bit(8'(p))));
      rd(8'hB4, v); chk("R8 status kept", v, 8'(p));
      handshake(); chk("R8 sweep drop", {7'd0, irq_req}, 8'h00);
    end

    // R5/R6 sweep over every enable pattern with base near wrap
    wr(8'hB0, 8'hFC);
    raise(8'hFF);
    for (int e = 0; e < 256; e++) begin
      wr(8'hB2, 8'(e));
      #1 chk("R5 wake sweep", {7'd0, wake}, (e != 0) ? 8'h01 : 8'h00);
      boundary();
      if (e == 0) chk("R7 none enabled", {7'd0, irq_req}, 8'h00);
      else begin
        chk("R6 enable sweep vec", irq_vec, 8'(8'hFC + top_bit(8'(e))));
        handshake();
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule